// File: doc/BRIEF.md
# Chip Select Unit with Boot Decode

This block turns bus addresses into four active-low chip selects and produces the cycle-ending acknowledge for the select that won. Coming out of reset it is in a boot mode. In boot mode select 0 answers every access at any address, so a boot memory can supply the first vectors from address zero. During boot mode select 0 behaves as a 16-bit port, always waits three states and ignores write protection.

Software ends boot mode by writing the select 0 base register with its valid bit set. From then on every select decodes with its own base and mask. The base register holds the block address, a write-protect bit and the valid bit. The mask register holds the don't-care address bits, the port width and a wait count. When several enabled selects match an address, the lowest-numbered one wins. An external 8-bit acknowledge that is sampled early enough stops the internal acknowledge for the rest of that access.

Top module: `cs_unit`

## Requirements
- R1: After reset all `cs_n` bits and `ack_n` are high and the unit is in boot mode.
- R2: In boot mode, `cs_n` reads 4'b1110 after the first clock edge that samples `as_n` low, for any address and either `rw` value.
- R3: In boot mode, `ack_n` goes low after the third clock edge that follows the start edge, and `ack_wide` is 1 while `ack_n` is low. `ack_wide` stays stable while `ack_n` stays low.
- R4: In boot mode, select 0 asserts on write accesses even when its write-protect bit is set.
- R5: In boot mode, selects 1 to 3 never assert, even when they are programmed valid and matching.
- R6: A write to the select 0 base register (`cfg_kind`=0, `cfg_idx`=0) with `cfg_wdata[0]`=1 ends boot mode. After that, select i matches when `((addr[23:8] ^ base_i) & ~mask_i) == 0`. The base word is {addr[17:2], wp[1], valid[0]}. The mask word is {mask[20:5], wide[4], waits[3:0]}.
- R7: A base address written to select 0 while in boot mode keeps decoding after boot mode ends.
- R8: Once boot mode has ended, only reset brings it back. Clearing select 0's valid bit does not.
- R9: When several enabled selects match, only the lowest-numbered one asserts.
- R10: Outside boot mode, `ack_n` goes low after the N-th edge following the start edge, where N is the winning select's wait count (0 to 15). `ack_wide` then equals that select's width bit.
- R11: A write access (`rw`=0) does not match a select whose write-protect bit is set. Decoding falls through to the next matching select.
- R12: If `ext_ack_n` is sampled low at an edge no later than the one where the wait count would be reached, `ack_n` stays high for the rest of the access.
- R13: One edge after `as_n` is sampled high, all `cs_n` bits and `ack_n` are high. The next strobe restarts the wait count.
- R14: An access that matches no select asserts no `cs_n` bit and no `ack_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 24 | Access address, held while `as_n` is low |
| rw | input | 1 | 1 = read, 0 = write |
| as_n | input | 1 | Active-low address strobe |
| ext_ack_n | input | 1 | Active-low external 8-bit acknowledge |
| cfg_we | input | 1 | Register write enable |
| cfg_idx | input | 2 | Select number of the written register |
| cfg_kind | input | 1 | 0 = base register, 1 = mask register |
| cfg_wdata | input | 21 | Register write data |
| cs_n | output | 4 | Active-low chip selects |
| ack_n | output | 1 | Active-low internal acknowledge |
| ack_wide | output | 1 | 1 = 16-bit port, 0 = 8-bit port, valid with `ack_n` |

## Verification
The hardest case to reach is the external acknowledge that lands exactly on the edge where the boot wait count expires. The bench first programs selects 1 to 3 and a write-protected select 0 while still in boot mode. It then drives `ext_ack_n` after each of edges 0 to 3 of a boot access, which covers both sides of the three-state boundary. Leaving boot mode without a reset is reached only by a register write, and the unit cannot go back except through `rst_n`. For that reason the bench runs the whole decode sweep over 256 address blocks in both directions, then clears the valid bit, and only at the end applies reset to check that boot mode returns.

// File: rtl/cs_pkg.sv
// Package: shared register-field positions and register-kind encoding
// for the chip select unit. Assumes the wait field sits at bit 0 of the
// mask word; the remaining mask fields are placed above it by the modules.
package cs_pkg;
    typedef enum logic {
        KIND_BASE = 1'b0,
        KIND_MASK = 1'b1
    } cs_kind_e;

    localparam int BASE_VALID_BIT = 0;
    localparam int BASE_WP_BIT    = 1;
    localparam int BASE_ADDR_LSB  = 2;
endpackage

// File: rtl/cs_regs.sv
// Module: cs_regs
// Holds base and mask registers for every select plus the boot-mode flag.
// Assumes writes arrive as single-cycle cfg_we pulses. The boot flag is
// set only by reset and cleared by a select 0 base write with valid = 1.
module cs_regs
    import cs_pkg::*;
#(
    parameter int NSEL   = 4,
    parameter int HI_W   = 16,
    parameter int WAIT_W = 4,
    parameter int IDX_W  = 2,
    parameter int CFG_W  = 21
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic                          cfg_kind,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output logic [NSEL-1:0][HI_W-1:0]     base_addr,
    output logic [NSEL-1:0][HI_W-1:0]     mask_addr,
    output logic [NSEL-1:0]               valid,
    output logic [NSEL-1:0]               wp,
    output logic [NSEL-1:0]               wide,
    output logic [NSEL-1:0][WAIT_W-1:0]   waits,
    output logic                          boot_mode
);
    localparam int WIDE_BIT  = WAIT_W;
    localparam int MADDR_LSB = WAIT_W + 1;

    // Register file update for all selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            mask_addr <= '0;
            valid     <= '0;
            wp        <= '0;
            wide      <= '0;
            waits     <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NSEL; i++) begin
                if (cfg_idx == IDX_W'(i)) begin
                    if (cfg_kind == KIND_BASE) begin
                        base_addr[i] <= cfg_wdata[BASE_ADDR_LSB +: HI_W];
                        wp[i]        <= cfg_wdata[BASE_WP_BIT];
                        valid[i]     <= cfg_wdata[BASE_VALID_BIT];
                    end else begin
                        mask_addr[i] <= cfg_wdata[MADDR_LSB +: HI_W];
                        wide[i]      <= cfg_wdata[WIDE_BIT];
                        waits[i]     <= cfg_wdata[0 +: WAIT_W];
                    end
                end
            end
        end
    end

    // Boot-mode flag: reset sets it, a valid select 0 base write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_mode <= 1'b1;
        end else if (cfg_we && cfg_idx == '0 && cfg_kind == KIND_BASE
                     && cfg_wdata[BASE_VALID_BIT]) begin
            boot_mode <= 1'b0;
        end
    end
endmodule

// File: rtl/cs_decode.sv
// Module: cs_decode
// Combinational address match for each select and priority pick of the
// lowest-numbered match. In boot mode it forces select 0 with the fixed
// boot width and wait count. Assumes addr_hi and rw are stable while sampled.
module cs_decode #(
    parameter int NSEL       = 4,
    parameter int HI_W       = 16,
    parameter int WAIT_W     = 4,
    parameter int IDX_W      = 2,
    parameter int BOOT_WAITS = 3
) (
    input  logic [HI_W-1:0]               addr_hi,
    input  logic                          rw,
    input  logic                          boot_mode,
    input  logic [NSEL-1:0][HI_W-1:0]     base_addr,
    input  logic [NSEL-1:0][HI_W-1:0]     mask_addr,
    input  logic [NSEL-1:0]               valid,
    input  logic [NSEL-1:0]               wp,
    input  logic [NSEL-1:0]               wide,
    input  logic [NSEL-1:0][WAIT_W-1:0]   waits,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx,
    output logic                          sel_wide,
    output logic [WAIT_W-1:0]             sel_waits
);
    logic [NSEL-1:0] match;

    // Per-select compare of unmasked address bits and write protection.
    for (genvar g = 0; g < NSEL; g++) begin : g_match
        assign match[g] = valid[g]
                        && (((addr_hi ^ base_addr[g]) & ~mask_addr[g]) == '0)
                        && !(wp[g] && !rw);
    end

    // Lowest-numbered match wins; boot mode overrides the whole decode.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NSEL - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        if (boot_mode) begin
            hit       = 1'b1;
            idx       = '0;
            sel_wide  = 1'b1;
            sel_waits = WAIT_W'(BOOT_WAITS);
        end else begin
            sel_wide  = wide[idx];
            sel_waits = waits[idx];
        end
    end
endmodule

// File: rtl/cs_timer.sv
// Module: cs_timer
// Access sequencer. It latches the decode result on the first edge that
// sees the strobe low, counts wait states, suppresses its own acknowledge
// after an external one, and releases everything one edge after the
// strobe is negated. Assumes the strobe stays high for at least one edge
// between accesses.
module cs_timer #(
    parameter int NSEL   = 4,
    parameter int WAIT_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              ext_ack_n,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic              sel_wide,
    input  logic [WAIT_W-1:0] sel_waits,
    output logic [NSEL-1:0]   cs_n,
    output logic              ack_n,
    output logic              ack_wide
);
    logic              active_q;
    logic              hit_q;
    logic              wide_q;
    logic              ext_seen_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WAIT_W-1:0] waits_q;
    logic [WAIT_W-1:0] cnt_q;

    // Access state: capture at start, count while active, clear on negation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            hit_q      <= 1'b0;
            wide_q     <= 1'b0;
            ext_seen_q <= 1'b0;
            idx_q      <= '0;
            waits_q    <= '0;
            cnt_q      <= '0;
        end else if (as_n) begin
            active_q   <= 1'b0;
            hit_q      <= 1'b0;
            ext_seen_q <= 1'b0;
            cnt_q      <= '0;
        end else if (!active_q) begin
            active_q   <= 1'b1;
            hit_q      <= hit;
            idx_q      <= idx;
            wide_q     <= sel_wide;
            waits_q    <= sel_waits;
            cnt_q      <= '0;
            ext_seen_q <= 1'b0;
        end else begin
            if (cnt_q != waits_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (!ext_ack_n) begin
                ext_seen_q <= 1'b1;
            end
        end
    end

    // Select outputs, one per select.
    for (genvar g = 0; g < NSEL; g++) begin : g_cs
        assign cs_n[g] = !(active_q && hit_q && idx_q == IDX_W'(g));
    end

    // Internal acknowledge once the count is reached and no external one was seen.
    assign ack_n    = !(active_q && hit_q && cnt_q == waits_q && !ext_seen_q);
    assign ack_wide = active_q && hit_q && wide_q;
endmodule

// File: rtl/cs_unit.sv
// Module: cs_unit (top)
// Chip select unit: register file, address decoder and access sequencer.
// Assumes addr and rw are held stable while as_n is low, and that register
// writes are not issued in the middle of an access.
module cs_unit #(
    parameter int ADDR_W     = 24,
    parameter int BLK_W      = 8,
    parameter int NSEL       = 4,
    parameter int WAIT_W     = 4,
    parameter int BOOT_WAITS = 3,
    parameter int IDX_W      = $clog2(NSEL),
    parameter int CFG_W      = ADDR_W - BLK_W + WAIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              as_n,
    input  logic              ext_ack_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_kind,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [NSEL-1:0]   cs_n,
    output logic              ack_n,
    output logic              ack_wide
);
    localparam int HI_W = ADDR_W - BLK_W;

    logic [NSEL-1:0][HI_W-1:0]   base_addr;
    logic [NSEL-1:0][HI_W-1:0]   mask_addr;
    logic [NSEL-1:0]             valid;
    logic [NSEL-1:0]             wp;
    logic [NSEL-1:0]             wide;
    logic [NSEL-1:0][WAIT_W-1:0] waits;
    logic                        boot_mode;
    logic                        hit;
    logic [IDX_W-1:0]            idx;
    logic                        sel_wide;
    logic [WAIT_W-1:0]           sel_waits;

    cs_regs #(
        .NSEL(NSEL), .HI_W(HI_W), .WAIT_W(WAIT_W), .IDX_W(IDX_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata),
        .base_addr(base_addr), .mask_addr(mask_addr), .valid(valid),
        .wp(wp), .wide(wide), .waits(waits), .boot_mode(boot_mode)
    );

    cs_decode #(
        .NSEL(NSEL), .HI_W(HI_W), .WAIT_W(WAIT_W), .IDX_W(IDX_W),
        .BOOT_WAITS(BOOT_WAITS)
    ) u_decode (
        .addr_hi(addr[ADDR_W-1:BLK_W]), .rw(rw), .boot_mode(boot_mode),
        .base_addr(base_addr), .mask_addr(mask_addr), .valid(valid),
        .wp(wp), .wide(wide), .waits(waits),
        .hit(hit), .idx(idx), .sel_wide(sel_wide), .sel_waits(sel_waits)
    );

    cs_timer #(
        .NSEL(NSEL), .WAIT_W(WAIT_W), .IDX_W(IDX_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ext_ack_n(ext_ack_n),
        .hit(hit), .idx(idx), .sel_wide(sel_wide), .sel_waits(sel_waits),
        .cs_n(cs_n), .ack_n(ack_n), .ack_wide(ack_wide)
    );
endmodule

// File: rtl/cs_unit_chk.sv
// Module: cs_unit_chk
// Property checker bound to cs_unit. It observes the ports and the boot flag.
module cs_unit_chk #(
    parameter int NSEL = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            as_n,
    input logic [NSEL-1:0] cs_n,
    input logic            ack_n,
    input logic            ack_wide,
    input logic            boot_mode
);
    // R13
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (cs_n == '1 && ack_n));

    // R9
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R5
    boot_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_mode |-> (cs_n[NSEL-1:1] == '1));

    // R8
    boot_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_mode |=> !boot_mode);

    // R14
    ack_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (cs_n != '1));

    // R3
    width_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(!ack_n)) |-> $stable(ack_wide));
endmodule

bind cs_unit cs_unit_chk #(.NSEL(NSEL)) u_chk (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n),
    .ack_n(ack_n), .ack_wide(ack_wide), .boot_mode(boot_mode)
);

// File: tb/cs_unit_tb.sv
// Bench for cs_unit: boot-mode sweep, full decode sweep over 256 blocks in
// both directions, targeted priority, protection and external-ack cases,
// and boot restore by reset.
module cs_unit_tb;
    localparam int ADDR_W = 24;
    localparam int HI_W   = 16;
    localparam int NSEL   = 4;
    localparam int CFG_W  = 21;
    localparam int WIN    = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rw = 1'b1;
    logic              as_n = 1'b1;
    logic              ext_ack_n = 1'b1;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_idx = '0;
    logic              cfg_kind = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [NSEL-1:0]   cs_n;
    logic              ack_n;
    logic              ack_wide;

    int total = 0;
    int bad = 0;

    // Bench model of the programmed state.
    logic            m_boot;
    logic [HI_W-1:0] m_base [NSEL];
    logic [HI_W-1:0] m_mask [NSEL];
    logic            m_valid [NSEL];
    logic            m_wp [NSEL];
    logic            m_wide [NSEL];
    int              m_waits [NSEL];

    always #2 clk = ~clk;

    cs_unit u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .as_n(as_n),
        .ext_ack_n(ext_ack_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata),
        .cs_n(cs_n), .ack_n(ack_n), .ack_wide(ack_wide)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_boot = 1'b1;
        for (int i = 0; i < NSEL; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_valid[i] = 1'b0;
            m_wp[i] = 1'b0; m_wide[i] = 1'b0; m_waits[i] = 0;
        end
    endtask

    task automatic wr_base(input int s, input logic [HI_W-1:0] b,
                           input logic p, input logic v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(s); cfg_kind = 1'b0;
        cfg_wdata = CFG_W'({b, p, v});
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[s] = b; m_wp[s] = p; m_valid[s] = v;
        if (s == 0 && v) m_boot = 1'b0;
    endtask

    task automatic wr_mask(input int s, input logic [HI_W-1:0] m,
                           input logic w, input int n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(s); cfg_kind = 1'b1;
        cfg_wdata = {m, w, 4'(n)};
        @(negedge clk);
        cfg_we = 1'b0;
        m_mask[s] = m; m_wide[s] = w; m_waits[s] = n;
    endtask

    function automatic int exp_sel(input logic [HI_W-1:0] h, input logic r);
        if (m_boot) return 0;
        for (int i = 0; i < NSEL; i++) begin
            if (m_valid[i] && ((h ^ m_base[i]) & ~m_mask[i]) == '0 && !(m_wp[i] && !r))
                return i;
        end
        return -1;
    endfunction

    // One complete access. ext_at < 0 means no external acknowledge;
    // otherwise it is driven after edge ext_at.
    task automatic access(input logic [ADDR_W-1:0] a, input logic r,
                          input int ext_at, input string tcs, input string tack);
        int es, ew, got;
        logic ewide;
        logic [NSEL-1:0] ecs;
        es = exp_sel(a[ADDR_W-1:8], r);
        ew = m_boot ? 3 : (es >= 0 ? m_waits[es] : 0);
        ewide = m_boot ? 1'b1 : (es >= 0 ? m_wide[es] : 1'b0);
        ecs = (es < 0) ? '1 : ~(NSEL'(1) << es);
        @(negedge clk);
        addr = a; rw = r; as_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(cs_n == ecs, tcs, "cs_n", cs_n, ecs);
        got = -1;
        for (int k = 0; k <= WIN; k++) begin
            if (k > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            if (got < 0 && !ack_n) begin
                got = k;
                chk(ack_wide == ewide, tack, "ack_wide", ack_wide, ewide);
            end
            if (k == ext_at) ext_ack_n = 1'b0;
        end
        if (es < 0 || (ext_at >= 0 && ext_at + 1 <= ew)) ew = -1;
        chk(got == ew, tack, "ack edge", got, ew);
        as_n = 1'b1; ext_ack_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(cs_n == '1 && ack_n, "R13", "release", {cs_n, ack_n}, 5'h1f);
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R13 watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cs_n == '1, "R1", "cs_n after reset", cs_n, 4'hf);
        chk(ack_n == 1'b1, "R1", "ack_n after reset", ack_n, 1);

        // Program everything while still in boot mode.
        wr_base(0, 16'h0010, 1'b1, 1'b0);
        wr_mask(0, 16'h0007, 1'b0, 1);
        wr_base(1, 16'h0018, 1'b0, 1'b1);
        wr_mask(1, 16'h000F, 1'b1, 2);
        wr_base(2, 16'h0040, 1'b1, 1'b1);
        wr_mask(2, 16'h003F, 1'b1, 0);
        wr_base(3, 16'h0000, 1'b0, 1'b1);
        wr_mask(3, 16'h007F, 1'b0, 5);

        // R2 R3 boot sweep, including the start vector addresses.
        access(24'h000000, 1'b1, -1, "R2", "R3");
        access(24'h000004, 1'b1, -1, "R2", "R3");
        for (int i = 0; i < 48; i++) begin
            access(24'((i * 24'h031F4B) ^ (i << 20)), 1'(i & 1), -1, "R2", "R3");
        end
        // R4: write into the protected select 0 range.
        access(24'h001234, 1'b0, -1, "R4", "R3");
        // R5: address matched by selects 1 and 3.
        access(24'h001A00, 1'b1, -1, "R5", "R3");
        // R12: external ack at or before the boot count, then too late.
        access(24'h000100, 1'b1, 0, "R2", "R12");
        access(24'h000200, 1'b1, 1, "R2", "R12");
        access(24'h000300, 1'b1, 2, "R2", "R12");
        access(24'h000400, 1'b1, 3, "R2", "R12");

        // R6: leave boot mode, select 0 keeps its earlier base.
        wr_base(0, 16'h0010, 1'b0, 1'b1);
        for (int h = 0; h < 256; h++) begin
            access({16'(h), 8'(h * 13)}, 1'b1, -1, "R6", "R10");
            access({16'(h), 8'(h * 7)}, 1'b0, -1, "R6", "R10");
        end
        // R7
        access(24'h001455, 1'b1, -1, "R7", "R10");
        // R9: selects 0, 1 and 3 all match.
        access(24'h001200, 1'b0, -1, "R9", "R10");
        // R11: write falls through the protected select 2 to select 3.
        access(24'h004500, 1'b0, -1, "R11", "R10");
        access(24'h004500, 1'b1, -1, "R11", "R10");
        // R12 in normal mode, select 3 with five waits.
        access(24'h002000, 1'b1, 1, "R6", "R12");
        access(24'h002000, 1'b1, 4, "R6", "R12");
        access(24'h002000, 1'b1, 5, "R6", "R12");

        // R8: clearing valid does not restore boot mode.
        wr_base(0, 16'h0010, 1'b0, 1'b0);
        access(24'h009000, 1'b1, -1, "R8", "R14");
        access(24'h001200, 1'b1, -1, "R8", "R10");

        // R8: reset restores boot mode.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(cs_n == '1 && ack_n, "R1", "state after second reset", {cs_n, ack_n}, 5'h1f);
        access(24'h009000, 1'b1, -1, "R8", "R3");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule